// File: doc/BRIEF.md
# Packed Sub-Word Transfer Sequencer

This block carries out the bus side of a single 32-bit debug data access. It takes one request (direction, address, size, increment mode and, for writes, a 32-bit word) and turns it into one or more transfers on a simple memory-bus master port. In packed mode with byte or halfword size, a single access becomes four byte or two halfword transfers. Read lanes are gathered into one 32-bit result, and the write word is scattered so that each transfer carries only its own lanes.

Between transfers the address moves by the transfer size. It wraps inside its aligned 1KB block, and the upper address bits never change. Register decoding and security gating sit outside; their results arrive as the request inputs. The bus port holds a request until the target answers with an acknowledge, which may carry an error flag.

Top module: `pks_seq_top`

## Requirements
- R1: With mode code 2 (packed) and size code 0 (byte), one access issues exactly four bus transfers, each with bus size code 0.
- R2: With mode code 2 and size code 1 (halfword), one access issues exactly two bus transfers, each with bus size code 1.
- R3: With size code 2 (word), in packed mode or in single mode (mode code 1), one access issues exactly one transfer with bus size code 2.
- R4: In single mode with byte size, one transfer is made at the request address. The read result carries only the lane picked by address bits [1:0]; all other lanes are zero.
- R5: On reads, each transfer's data lanes are placed into the result at the lanes its own address bits [1:0] select (byte: the one lane equal to bits [1:0]; halfword: the two lanes sharing bit 1; word: all four). Lanes never read are zero.
- R6: On writes, the bus write data carries the request word's bytes in the lanes the transfer's own address selects and zero in every other lane. Address and data stay stable until acknowledged.
- R7: Mode codes 1 and 2 move the address by 1, 2 or 4 bytes after each error-free transfer. Address bits [9:0] wrap modulo 1024 and the upper bits stay unchanged. The address output shows the next address when the access ends.
- R8: The busy output is high from the cycle after acceptance until the last response is taken. Done is high for exactly one cycle, the cycle after the last response, and busy is low in that cycle.
- R9: An error response ends the access at once, with no further transfers. Err is high with done, and the address output stays at the failing transfer's address.
- R10: A request presented while busy, or in the done cycle, is ignored: it issues no transfer and leaves the ongoing access unchanged.
- R11: Mode code 0 (no increment) issues one transfer of the given size, and the address output keeps the request address.
- R12: Mode code 3 or size code 3 is reserved. Such a request issues no bus transfer, and done and err rise together in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 0 no increment, 1 single, 2 packed, 3 reserved |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Start address |
| req_wdata | input | DATA_W | Write word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Access ended with an error (valid with done) |
| rdata | output | DATA_W | Gathered read word |
| addr_out | output | ADDR_W | Current or next address |
| bus_req | output | 1 | Bus transfer request |
| bus_write | output | 1 | Bus direction |
| bus_addr | output | ADDR_W | Bus address |
| bus_size | output | 2 | Bus transfer size code |
| bus_wdata | output | DATA_W | Lane-masked write data |
| bus_ack | input | 1 | Target response for the held request |
| bus_err | input | 1 | Error flag with the response |
| bus_rdata | input | DATA_W | Read data with the response |

## Verification
The bench targets lane placement when the start address is not lane-aligned. A design that used the beat count instead of the address bits to pick lanes would build a rotated read word, or drive write bytes on the wrong lanes. A halfword packed access starting two bytes below a 1KB boundary checks the wrap: a design that carried into bit 10 would leave the block. An error on the third byte beat checks early termination: a faulty design would issue a fourth transfer or advance past the failing address. Reserved codes, and requests made while busy, must issue no transfer at all.

// File: rtl/pks_pkg.sv
package pks_pkg;

   typedef enum logic [1:0] {
      INC_OFF    = 2'd0,
      INC_SINGLE = 2'd1,
      INC_PACKED = 2'd2,
      INC_RSVD   = 2'd3
   } inc_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xfer_size_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_XFER = 1'b1
   } seq_state_e;

   // number of bus beats one debug access expands into
   function automatic logic [2:0] beat_count(inc_mode_e m, xfer_size_e s);
      if (m == INC_PACKED && s == SZ_BYTE)      return 3'd4;
      else if (m == INC_PACKED && s == SZ_HALF) return 3'd2;
      else                                      return 3'd1;
   endfunction

endpackage

// File: rtl/pks_addr_step.sv
module pks_addr_step #(
   parameter int ADDR_W    = 32,
   parameter int WRAP_BITS = 10
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [1:0]        size,
   output logic [ADDR_W-1:0] addr_nxt
);

   localparam logic [WRAP_BITS-1:0] ONE = WRAP_BITS'(1);

   logic [WRAP_BITS-1:0] step;
   logic [WRAP_BITS-1:0] low_nxt;

   assign step    = ONE << size;
   assign low_nxt = addr_in[WRAP_BITS-1:0] + step;

   generate
      if (WRAP_BITS == ADDR_W) begin : g_full
         assign addr_nxt = low_nxt;
      end else begin : g_wrap
         assign addr_nxt = {addr_in[ADDR_W-1:WRAP_BITS], low_nxt};
      end
   endgenerate

endmodule

// File: rtl/pks_lane_unit.sv
module pks_lane_unit #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]                      size,
   input  logic [$clog2(DATA_W/8)-1:0]     lo,
   input  logic [DATA_W-1:0]               wdata,
   input  logic [DATA_W-1:0]               bus_rdata,
   input  logic [DATA_W-1:0]               acc,
   output logic [DATA_W/8-1:0]             lane_en,
   output logic [DATA_W-1:0]               bus_wdata,
   output logic [DATA_W-1:0]               acc_nxt
);

   localparam int LANES = DATA_W / 8;
   localparam int LO_W  = $clog2(LANES);

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         localparam logic [LO_W-1:0] KIDX = LO_W'(k);
         // a lane is active when it shares every index bit above the size
         assign lane_en[k]          = (((KIDX ^ lo) >> size) == '0);
         assign bus_wdata[8*k +: 8] = lane_en[k] ? wdata[8*k +: 8] : 8'h00;
         assign acc_nxt[8*k +: 8]   = lane_en[k] ? bus_rdata[8*k +: 8] : acc[8*k +: 8];
      end
   endgenerate

endmodule

// File: rtl/pks_seq_top.sv
module pks_seq_top
   import pks_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int WRAP_BITS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_mode,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr_out,
   output logic              bus_req,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_size,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic              bus_err,
   input  logic [DATA_W-1:0] bus_rdata
);

   localparam int LANES  = DATA_W / 8;
   localparam int LO_W   = $clog2(LANES);
   localparam int BEAT_W = $clog2(LANES);

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("pks_seq_top: DATA_W must be 32");
      end
      if (WRAP_BITS < LO_W || WRAP_BITS > ADDR_W) begin : g_bad_wrap
         $error("pks_seq_top: WRAP_BITS out of range");
      end
   endgenerate

   seq_state_e        state_q;
   logic              done_q, err_q, wr_q, adv_q;
   xfer_size_e        size_q;
   logic [BEAT_W-1:0] rem_q;
   logic [ADDR_W-1:0] addr_q, addr_step;
   logic [DATA_W-1:0] wdat_q, acc_q, acc_nxt;
   logic [LANES-1:0]  lane_en;

   inc_mode_e  in_mode;
   xfer_size_e in_size;
   logic       accept, rsvd_req;
   logic [2:0] beats;

   assign in_mode  = inc_mode_e'(req_mode);
   assign in_size  = xfer_size_e'(req_size);
   assign accept   = req_valid && (state_q == ST_IDLE) && !done_q;
   assign rsvd_req = (in_mode == INC_RSVD) || (in_size == SZ_RSVD);
   assign beats    = beat_count(in_mode, in_size);

   pks_addr_step #(.ADDR_W(ADDR_W), .WRAP_BITS(WRAP_BITS)) u_step (
      .addr_in  (addr_q),
      .size     (size_q),
      .addr_nxt (addr_step)
   );

   pks_lane_unit #(.DATA_W(DATA_W)) u_lane (
      .size      (size_q),
      .lo        (addr_q[LO_W-1:0]),
      .wdata     (wdat_q),
      .bus_rdata (bus_rdata),
      .acc       (acc_q),
      .lane_en   (lane_en),
      .bus_wdata (bus_wdata),
      .acc_nxt   (acc_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         wr_q    <= 1'b0;
         adv_q   <= 1'b0;
         size_q  <= SZ_WORD;
         rem_q   <= '0;
         addr_q  <= '0;
         wdat_q  <= '0;
         acc_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  err_q <= 1'b0;
                  if (rsvd_req) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else begin
                     state_q <= ST_XFER;
                     addr_q  <= req_addr;
                     wdat_q  <= req_wdata;
                     wr_q    <= req_write;
                     size_q  <= in_size;
                     adv_q   <= (in_mode != INC_OFF);
                     rem_q   <= BEAT_W'(beats - 3'd1);
                     acc_q   <= '0;
                  end
               end
            end
            ST_XFER: begin
               if (bus_ack) begin
                  if (bus_err) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     err_q   <= 1'b1;
                  end else begin
                     if (!wr_q) acc_q <= acc_nxt;
                     if (adv_q) addr_q <= addr_step;
                     if (rem_q == '0) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        rem_q <= rem_q - BEAT_W'(1);
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q == ST_XFER);
   assign done      = done_q;
   assign err       = err_q;
   assign rdata     = acc_q;
   assign addr_out  = addr_q;
   assign bus_req   = busy;
   assign bus_write = wr_q;
   assign bus_addr  = addr_q;
   assign bus_size  = size_q;

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata));

   // R9
   err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack && bus_err |=> done && err && !busy && $stable(addr_out));

   // R5
   lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> $countones(lane_en) == (1 << bus_size));

   generate
      if (WRAP_BITS < ADDR_W) begin : g_wrap_chk
         // R7
         upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_req && bus_ack && !bus_err |=>
               addr_out[ADDR_W-1:WRAP_BITS] == $past(addr_out[ADDR_W-1:WRAP_BITS]));
      end
   endgenerate

endmodule

// File: tb/pks_seq_top_tb_top.sv
module pks_seq_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_mode = 2'd0, req_size = 2'd2;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        busy, done, err, bus_req, bus_write;
   logic [31:0] rdata, addr_out, bus_addr, bus_wdata;
   logic [1:0]  bus_size;
   logic        bus_ack = 1'b0, bus_err = 1'b0;
   logic [31:0] bus_rdata = '0;

   int checks = 0, fails = 0;
   int slv_lat = 0, err_at = -1, err_base = 0;
   int log_total = 0, wcnt = 0;
   logic [31:0] log_addr  [0:255];
   logic [31:0] log_wdata [0:255];
   logic [1:0]  log_size  [0:255];
   logic        log_busy  [0:255];
   logic        log_wr    [0:255];

   always #2 clk = ~clk;

   pks_seq_top dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_mode(req_mode), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .busy(busy), .done(done), .err(err),
      .rdata(rdata), .addr_out(addr_out), .bus_req(bus_req),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
      .bus_rdata(bus_rdata)
   );

   function automatic logic [31:0] slv_word(input logic [31:0] a);
      return {a[7:0] ^ 8'h3C, a[7:0] ^ 8'hC3, a[7:0] ^ 8'h5A, a[7:0] ^ 8'hA5};
   endfunction

   // target model: answers after slv_lat idle cycles, logs every transfer
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ack = 1'b0;
         wcnt = 0;
      end else if (bus_ack) begin
         bus_ack = 1'b0;
         bus_err = 1'b0;
      end else if (bus_req) begin
         if (wcnt < slv_lat) wcnt++;
         else begin
            wcnt = 0;
            bus_ack   = 1'b1;
            bus_err   = ((log_total - err_base) == err_at);
            bus_rdata = slv_word(bus_addr);
            log_addr[log_total & 255]  = bus_addr;
            log_wdata[log_total & 255] = bus_wdata;
            log_size[log_total & 255]  = bus_size;
            log_busy[log_total & 255]  = busy;
            log_wr[log_total & 255]    = bus_write;
            log_total++;
         end
      end
   end

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic lane_hit(input int k, input logic [1:0] lo, input logic [1:0] sz);
      if (sz == 2'd0) return (k == int'(lo));
      if (sz == 2'd1) return ((k / 2) == int'(lo[1]));
      return 1'b1;
   endfunction

   task automatic start_req(input logic w, input logic [1:0] m, input logic [1:0] s,
                            input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      req_write = w; req_mode = m; req_size = s; req_addr = a; req_wdata = d;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(done, req, "done seen", {63'd0, done}, 64'd1);
   endtask

   // full model check of one access against the requirements
   task automatic run_check(input string req, input logic w, input logic [1:0] m,
                            input logic [1:0] s, input logic [31:0] a,
                            input logic [31:0] d, input int fail_beat);
      int base, nb, step, got, exp_n;
      logic [31:0] cur, expr, expw;
      @(negedge clk);
      base = log_total;
      err_base = log_total;
      err_at = fail_beat;
      start_req(w, m, s, a, d);
      wait_done(req);
      got = log_total - base;
      nb = (m == 2'd2 && s == 2'd0) ? 4 : (m == 2'd2 && s == 2'd1) ? 2 : 1;
      exp_n = (fail_beat >= 0 && fail_beat < nb) ? fail_beat + 1 : nb;
      chk(got == exp_n, req, "transfer count", 64'(got), 64'(exp_n));
      step = 1 << s;
      cur = a;
      expr = '0;
      for (int i = 0; i < exp_n && i < got; i++) begin
         logic [31:0] sw;
         chk(log_addr[(base+i)&255] == cur, req, "beat address",
             64'(log_addr[(base+i)&255]), 64'(cur));
         chk(log_size[(base+i)&255] == s, req, "beat size",
             64'(log_size[(base+i)&255]), 64'(s));
         chk(log_wr[(base+i)&255] == w, req, "beat direction",
             64'(log_wr[(base+i)&255]), 64'(w));
         sw = slv_word(cur);
         expw = '0;
         for (int k = 0; k < 4; k++)
            if (lane_hit(k, cur[1:0], s)) begin
               expw[8*k +: 8] = d[8*k +: 8];
               if (i != fail_beat) expr[8*k +: 8] = sw[8*k +: 8];
            end
         if (w) chk(log_wdata[(base+i)&255] == expw, "R6", "lane write data",
                    64'(log_wdata[(base+i)&255]), 64'(expw));
         if (i != fail_beat && m != 2'd0)
            cur = {cur[31:10], cur[9:0] + 10'(step)};
      end
      chk(err == (fail_beat >= 0 && fail_beat < nb), req, "err flag",
          64'(err), 64'(fail_beat >= 0 && fail_beat < nb));
      chk(addr_out == cur, "R7", "final address", 64'(addr_out), 64'(cur));
      if (!w) chk(rdata == expr, "R5", "gathered read word", 64'(rdata), 64'(expr));
      chk(!busy, "R8", "busy low with done", 64'(busy), 64'd0);
      @(negedge clk);
      chk(!done, "R8", "done single cycle", 64'(done), 64'd0);
      err_at = -1;
   endtask

   task automatic t_reset;
      chk(!busy && !done && !bus_req && !err, "R8", "reset outputs idle",
          {60'd0, busy, done, bus_req, err}, 64'd0);
   endtask

   task automatic t_pack_byte;   // R1 R5
      run_check("R1", 1'b0, 2'd2, 2'd0, 32'h2000_0101, 32'h0, -1);
   endtask

   task automatic t_pack_half;   // R2 R6
      run_check("R2", 1'b1, 2'd2, 2'd1, 32'h3000_0040, 32'hCAFE_BEEF, -1);
      run_check("R2", 1'b0, 2'd2, 2'd1, 32'h3000_0082, 32'h0, -1);
   endtask

   task automatic t_word;        // R3
      run_check("R3", 1'b0, 2'd2, 2'd2, 32'h4000_0010, 32'h0, -1);
      run_check("R3", 1'b1, 2'd1, 2'd2, 32'h4000_0020, 32'h1234_5678, -1);
   endtask

   task automatic t_single;      // R4
      run_check("R4", 1'b0, 2'd1, 2'd0, 32'h5000_0203, 32'h0, -1);
      chk(rdata[23:0] == 24'd0, "R4", "unread lanes zero", 64'(rdata), 64'd0);
      run_check("R4", 1'b1, 2'd1, 2'd0, 32'h5000_0201, 32'hA1B2_C3D4, -1);
   endtask

   task automatic t_wrap;        // R7
      slv_lat = 1;
      run_check("R7", 1'b0, 2'd2, 2'd1, 32'h6000_07FE, 32'h0, -1);
      run_check("R7", 1'b1, 2'd2, 2'd0, 32'h6000_0BFE, 32'h0102_0304, -1);
      slv_lat = 0;
   endtask

   task automatic t_busy;        // R8
      int base;
      slv_lat = 2;
      base = log_total;
      run_check("R8", 1'b0, 2'd2, 2'd0, 32'h7000_0000, 32'h0, -1);
      for (int i = 0; i < 4; i++)
         chk(log_busy[(base+i)&255], "R8", "busy during beat", 64'(log_busy[(base+i)&255]), 64'd1);
      slv_lat = 0;
   endtask

   task automatic t_error;       // R9
      run_check("R9", 1'b0, 2'd2, 2'd0, 32'h8000_0004, 32'h0, 2);
      chk(addr_out == 32'h8000_0006, "R9", "address at failing beat", 64'(addr_out), 64'h8000_0006);
   endtask

   task automatic t_ignore;      // R10
      int base;
      base = log_total;
      start_req(1'b0, 2'd2, 2'd0, 32'h9000_0010, 32'h0);
      req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_size = 2'd2;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done("R10");
      req_valid = 1'b1;   // held through the done cycle
      @(negedge clk);
      req_valid = 1'b0;
      repeat (6) @(negedge clk);
      chk((log_total - base) == 4, "R10", "no extra transfers", 64'(log_total - base), 64'd4);
      chk(log_addr[base & 255] == 32'h9000_0010, "R10", "first beat address kept",
          64'(log_addr[base & 255]), 64'h9000_0010);
      chk(addr_out == 32'h9000_0014, "R10", "address unaffected", 64'(addr_out), 64'h9000_0014);
      chk(!busy, "R10", "idle afterwards", 64'(busy), 64'd0);
   endtask

   task automatic t_off;         // R11
      run_check("R11", 1'b0, 2'd0, 2'd0, 32'hA000_0102, 32'h0, -1);
      run_check("R11", 1'b1, 2'd0, 2'd1, 32'hA000_0200, 32'h5566_7788, -1);
   endtask

   task automatic t_rsvd;        // R12
      int base;
      logic [1:0] ms [2] = '{2'd3, 2'd1};
      logic [1:0] ss [2] = '{2'd0, 2'd3};
      for (int j = 0; j < 2; j++) begin
         base = log_total;
         start_req(1'b0, ms[j], ss[j], 32'hB000_0000, 32'h0);
         chk(done && err, "R12", "done and err next cycle", {62'd0, done, err}, 64'd3);
         repeat (3) @(negedge clk);
         chk(log_total == base, "R12", "no bus transfer", 64'(log_total - base), 64'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_pack_byte();
      t_pack_half();
      t_word();
      t_single();
      t_wrap();
      t_busy();
      t_error();
      t_ignore();
      t_off();
      t_rsvd();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule